// File: doc/BRIEF.md
# Backlight Inactivity Dim and Off Controller

This block chooses the brightness code that a backlight current stage should aim for. Three ambient operating levels each hold their own pair of brightness codes, one for full brightness and one for the dimmed state, and a two-bit selector picks the pair in use. Software turns the backlight on or off with an enable bit, and it can ask for the dimmed code with a dim bit. Each bit is written through its own strobe.

Two inactivity countdowns run on a once-per-second tick. When the dim countdown runs out, the block sets the dim bit by itself. When the off countdown runs out, the block clears the enable bit by itself. With both countdowns programmed, the backlight therefore steps from full to dim and then to off. Writing enable to one again, or clearing the dim bit, restarts the affected countdowns. When keypad wake is allowed, a key press acts like a software write of enable to one. Fading between codes, the current sink, light sensing and register access are handled by other blocks.

Top module: `bl_dimoff_ctrl`

## Requirements
- R1: `level_sel` chooses the code pair: 00 selects the day pair, 01 the office pair, 10 the dark pair, and 11 also selects the dark pair. The selector acts on the output combinationally.
- R2: After reset, and whenever `en_state` is 0, `target_code` is 0 and `bl_on` is 0. When `en_state` is 1, `target_code` is the selected maximum code while `dim_state` is 0, and the selected dim code while `dim_state` is 1. `bl_on` follows `en_state`.
- R3: A strobe `en_wr` with `en_wdata`=1 gives `en_state`=1 and `dim_state`=0 on the next cycle, and it reloads both countdowns to their full length, even if the backlight is already on.
- R4: A strobe `en_wr` with `en_wdata`=0 (and no wake in the same cycle) gives `en_state`=0 and `dim_state`=0 on the next cycle, and it stops both countdowns. `dim_state` is never 1 while `en_state` is 0.
- R5: With a nonzero `dim_tcode` at the last restart, `dim_state` becomes 1 on the cycle after the N-th `tick_1hz` pulse that follows the restart cycle. N is the length of that code in seconds.
- R6: With a nonzero `off_tcode` at the last enable-set, `en_state` and `dim_state` become 0 on the cycle after the N-th tick pulse that follows that cycle. The off countdown is not restarted by dim activity.
- R7: Timer code lengths in seconds: codes 1 to 10 give 10 times the code. Code 11 gives 105, 12 gives 110, 13 gives 114, 14 gives 117 and 15 gives 120. Code 0 disables that countdown.
- R8: While on, a `dim_wr` strobe with `dim_wdata`=0 clears `dim_state` next cycle and restarts only the dim countdown. With `dim_wdata`=1 it sets `dim_state`. While off, `dim_wr` has no effect.
- R9: A `key_press` pulse with `key_wake_en`=1 behaves exactly as an enable-set (R3). With `key_wake_en`=0 it has no effect.
- R10: No clamping: a dim code larger than the maximum code is output unchanged while dimmed.
- R11: Priorities in one cycle: an enable-set beats an enable-clear. An enable-clear beats a dim write or an expiry. A dim write beats a dim expiry. An off expiry beats a dim write.
- R12: A countdown uses the code it sampled at its restart. Changing a code mid-count does not alter the running countdown.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| en_wr | input | 1 | Write strobe for the enable bit |
| en_wdata | input | 1 | Value written to the enable bit |
| dim_wr | input | 1 | Write strobe for the dim bit |
| dim_wdata | input | 1 | Value written to the dim bit |
| level_sel | input | 2 | Operating level selector |
| day_max | input | 7 | Day full-brightness code |
| day_dim | input | 7 | Day dimmed code |
| office_max | input | 7 | Office full-brightness code |
| office_dim | input | 7 | Office dimmed code |
| dark_max | input | 7 | Dark full-brightness code |
| dark_dim | input | 7 | Dark dimmed code |
| dim_tcode | input | 4 | Dim countdown code |
| off_tcode | input | 4 | Off countdown code |
| key_press | input | 1 | One-cycle key press pulse |
| key_wake_en | input | 1 | Allows key presses to turn the backlight on |
| tick_1hz | input | 1 | One-cycle pulse once per second |
| target_code | output | 7 | Brightness code requested |
| en_state | output | 1 | Live enable bit |
| dim_state | output | 1 | Live dim bit |
| bl_on | output | 1 | Backlight on flag |

## Verification
The hardest cases to reach are the same-cycle collisions: a software dim write or an enable-clear landing on the exact tick where a countdown expires. A directed sequence cannot easily line up strobes with an expiry that lies dozens of ticks away. The bench therefore ends with a long pseudo-random phase. That phase uses the shortest codes and frequent strobes, and it changes codes mid-count, so expiries and writes coincide many times. Every output is compared against a behavioural model on every cycle. Directed phases before that cover the longest code and the exact expiry tick.

// File: rtl/bl_dimoff_pkg.sv
package bl_dimoff_pkg;

    localparam int unsigned BRT_W   = 7;
    localparam int unsigned TCODE_W = 4;
    localparam int unsigned SEC_W   = 7;

    typedef enum logic [1:0] {
        LVL_DAY    = 2'b00,
        LVL_OFFICE = 2'b01,
        LVL_DARK   = 2'b10,
        LVL_DARK_B = 2'b11
    } lvl_e;

    typedef struct packed {
        logic [BRT_W-1:0] max_code;
        logic [BRT_W-1:0] dim_code;
    } lvl_pair_t;

    // Events seen by the control state in one cycle
    typedef struct packed {
        logic set_on;    // enable write 1 or key wake
        logic clr_on;    // enable write 0
        logic dim_wr;
        logic dim_val;
        logic dim_exp;
        logic off_exp;
    } ctl_evt_t;

    // Countdown length in seconds for a timer code; 0 means disabled
    function automatic logic [SEC_W-1:0] tcode_secs(input logic [TCODE_W-1:0] c);
        logic [SEC_W-1:0] s;
        case (c)
            4'd0:    s = SEC_W'(0);
            4'd11:   s = SEC_W'(105);
            4'd12:   s = SEC_W'(110);
            4'd13:   s = SEC_W'(114);
            4'd14:   s = SEC_W'(117);
            4'd15:   s = SEC_W'(120);
            default: s = SEC_W'(c) * SEC_W'(10);
        endcase
        return s;
    endfunction

endpackage

// File: rtl/bl_level_sel.sv
module bl_level_sel
    import bl_dimoff_pkg::*;
#(
    parameter int unsigned W = BRT_W
) (
    input  logic [1:0]   level_sel,
    input  logic [W-1:0] day_max,
    input  logic [W-1:0] day_dim,
    input  logic [W-1:0] office_max,
    input  logic [W-1:0] office_dim,
    input  logic [W-1:0] dark_max,
    input  logic [W-1:0] dark_dim,
    output logic [W-1:0] sel_max,
    output logic [W-1:0] sel_dim
);
    lvl_e lvl;
    assign lvl = lvl_e'(level_sel);

    always_comb begin
        unique case (lvl)
            LVL_DAY: begin
                sel_max = day_max;
                sel_dim = day_dim;
            end
            LVL_OFFICE: begin
                sel_max = office_max;
                sel_dim = office_dim;
            end
            default: begin
                sel_max = dark_max;
                sel_dim = dark_dim;
            end
        endcase
    end
endmodule

// File: rtl/bl_hold_timer.sv
module bl_hold_timer
    import bl_dimoff_pkg::*;
#(
    parameter int unsigned CW = TCODE_W,
    parameter int unsigned SW = SEC_W
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          restart,
    input  logic          run,
    input  logic          tick,
    input  logic [CW-1:0] code,
    output logic          expire
);
    logic [SW-1:0] cnt_q;
    logic          act_q;

    // Expiry is seen on the tick that consumes the last second
    assign expire = act_q && tick && (cnt_q == SW'(1));

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q <= '0;
            act_q <= 1'b0;
        end else if (restart) begin
            cnt_q <= SW'(tcode_secs(TCODE_W'(code)));
            act_q <= (code != '0);
        end else if (!run) begin
            act_q <= 1'b0;
        end else if (act_q && tick) begin
            cnt_q <= cnt_q - SW'(1);
            if (cnt_q == SW'(1)) act_q <= 1'b0;
        end
    end
endmodule

// File: rtl/bl_ctrl_state.sv
module bl_ctrl_state
    import bl_dimoff_pkg::*;
(
    input  logic     clk,
    input  logic     rst,
    input  ctl_evt_t evt,
    output logic     en_q,
    output logic     dim_q,
    output logic     rs_dim,
    output logic     rs_off
);
    logic en_n, dim_n;

    always_comb begin
        en_n   = en_q;
        dim_n  = dim_q;
        rs_dim = 1'b0;
        rs_off = 1'b0;
        if (evt.set_on) begin
            en_n   = 1'b1;
            dim_n  = 1'b0;
            rs_dim = 1'b1;
            rs_off = 1'b1;
        end else if (evt.clr_on) begin
            en_n  = 1'b0;
            dim_n = 1'b0;
        end else if (en_q) begin
            if (evt.dim_wr) begin
                dim_n = evt.dim_val;
                if (!evt.dim_val) rs_dim = 1'b1;
            end else if (evt.dim_exp) begin
                dim_n = 1'b1;
            end
            if (evt.off_exp) begin
                en_n  = 1'b0;
                dim_n = 1'b0;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            en_q  <= 1'b0;
            dim_q <= 1'b0;
        end else begin
            en_q  <= en_n;
            dim_q <= dim_n;
        end
    end
endmodule

// File: rtl/bl_dimoff_ctrl.sv
module bl_dimoff_ctrl
    import bl_dimoff_pkg::*;
#(
    parameter int unsigned BW = BRT_W,
    parameter int unsigned CW = TCODE_W,
    parameter int unsigned SW = SEC_W
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          en_wr,
    input  logic          en_wdata,
    input  logic          dim_wr,
    input  logic          dim_wdata,
    input  logic [1:0]    level_sel,
    input  logic [BW-1:0] day_max,
    input  logic [BW-1:0] day_dim,
    input  logic [BW-1:0] office_max,
    input  logic [BW-1:0] office_dim,
    input  logic [BW-1:0] dark_max,
    input  logic [BW-1:0] dark_dim,
    input  logic [CW-1:0] dim_tcode,
    input  logic [CW-1:0] off_tcode,
    input  logic          key_press,
    input  logic          key_wake_en,
    input  logic          tick_1hz,
    output logic [BW-1:0] target_code,
    output logic          en_state,
    output logic          dim_state,
    output logic          bl_on
);
    localparam int unsigned NTMR = 2;   // index 0: dim, 1: off

    logic [BW-1:0] sel_max, sel_dim;
    logic          en_q, dim_q;
    logic [NTMR-1:0]         tmr_rs, tmr_exp;
    logic [NTMR-1:0][CW-1:0] tmr_code;
    ctl_evt_t      evt;

    bl_level_sel #(.W(BW)) u_lvl (
        .level_sel (level_sel),
        .day_max   (day_max),
        .day_dim   (day_dim),
        .office_max(office_max),
        .office_dim(office_dim),
        .dark_max  (dark_max),
        .dark_dim  (dark_dim),
        .sel_max   (sel_max),
        .sel_dim   (sel_dim)
    );

    assign evt.set_on  = (en_wr && en_wdata) || (key_press && key_wake_en);
    assign evt.clr_on  = en_wr && !en_wdata;
    assign evt.dim_wr  = dim_wr;
    assign evt.dim_val = dim_wdata;
    assign evt.dim_exp = tmr_exp[0];
    assign evt.off_exp = tmr_exp[1];

    bl_ctrl_state u_st (
        .clk   (clk),
        .rst   (rst),
        .evt   (evt),
        .en_q  (en_q),
        .dim_q (dim_q),
        .rs_dim(tmr_rs[0]),
        .rs_off(tmr_rs[1])
    );

    assign tmr_code[0] = dim_tcode;
    assign tmr_code[1] = off_tcode;

    for (genvar gi = 0; gi < NTMR; gi++) begin : g_tmr
        bl_hold_timer #(.CW(CW), .SW(SW)) u_tmr (
            .clk    (clk),
            .rst    (rst),
            .restart(tmr_rs[gi]),
            .run    (en_q),
            .tick   (tick_1hz),
            .code   (tmr_code[gi]),
            .expire (tmr_exp[gi])
        );
    end

    assign target_code = !en_q ? '0 : (dim_q ? sel_dim : sel_max);
    assign en_state    = en_q;
    assign dim_state   = dim_q;
    assign bl_on       = en_q;
endmodule

// File: rtl/bl_dimoff_chk.sv
module bl_dimoff_chk #(
    parameter int unsigned BW = 7
) (
    input logic          clk,
    input logic          rst,
    input logic          en_wr,
    input logic          en_wdata,
    input logic          dim_wr,
    input logic          dim_wdata,
    input logic          key_press,
    input logic          key_wake_en,
    input logic [1:0]    level_sel,
    input logic [BW-1:0] office_max,
    input logic [BW-1:0] dark_dim,
    input logic [BW-1:0] target_code,
    input logic          en_state,
    input logic          dim_state,
    input logic          bl_on
);
    p_off_zero_r2: assert property (@(posedge clk) disable iff (rst)
        !en_state |-> (target_code == '0) && !bl_on);

    p_dim_needs_on_r4: assert property (@(posedge clk) disable iff (rst)
        dim_state |-> en_state);

    p_enable_set_r3: assert property (@(posedge clk) disable iff (rst)
        en_wr && en_wdata |=> en_state && !dim_state);

    p_key_wake_r9: assert property (@(posedge clk) disable iff (rst)
        key_press && key_wake_en |=> en_state && !dim_state);

    p_clear_r4: assert property (@(posedge clk) disable iff (rst)
        en_wr && !en_wdata && !(key_press && key_wake_en) |=> !en_state);

    p_dim_release_r8: assert property (@(posedge clk) disable iff (rst)
        en_state && dim_wr && !dim_wdata && !en_wr |=> !dim_state);

    p_max_sel_r1: assert property (@(posedge clk) disable iff (rst)
        en_state && !dim_state && (level_sel == 2'b01) |-> target_code == office_max);

    p_no_clamp_r10: assert property (@(posedge clk) disable iff (rst)
        en_state && dim_state && (level_sel == 2'b10) |-> target_code == dark_dim);
endmodule

bind bl_dimoff_ctrl bl_dimoff_chk #(.BW(BW)) u_chk (
    .clk        (clk),
    .rst        (rst),
    .en_wr      (en_wr),
    .en_wdata   (en_wdata),
    .dim_wr     (dim_wr),
    .dim_wdata  (dim_wdata),
    .key_press  (key_press),
    .key_wake_en(key_wake_en),
    .level_sel  (level_sel),
    .office_max (office_max),
    .dark_dim   (dark_dim),
    .target_code(target_code),
    .en_state   (en_state),
    .dim_state  (dim_state),
    .bl_on      (bl_on)
);

// File: tb/sim_bl_dimoff_ctrl.sv
module sim_bl_dimoff_ctrl;
    logic clk = 1'b0;
    logic rst = 1'b1;
    logic en_wr = 0, en_wdata = 0, dim_wr = 0, dim_wdata = 0;
    logic [1:0] level_sel = 2'b00;
    logic [6:0] day_max = 7'd100, day_dim = 7'd20;
    logic [6:0] office_max = 7'd60, office_dim = 7'd90;
    logic [6:0] dark_max = 7'd30, dark_dim = 7'd5;
    logic [3:0] dim_tcode = 0, off_tcode = 0;
    logic key_press = 0, key_wake_en = 0, tick_1hz = 0;
    logic [6:0] target_code;
    logic en_state, dim_state, bl_on;

    always #10 clk = ~clk;   // 50 MHz

    bl_dimoff_ctrl u0 (.*);

    int vectors = 0, errors = 0, wd = 0;
    string cur_req = "R2";
    bit tick_run = 0;
    bit tick_ph = 0;

    // reference model state
    int m_en = 0, m_dim = 0, m_dl = 0, m_ol = 0;

    function automatic int secs(int c);
        if (c == 0) return 0;
        if (c <= 10) return 10 * c;
        case (c)
            11: return 105;
            12: return 110;
            13: return 114;
            14: return 117;
            default: return 120;
        endcase
    endfunction

    function automatic int exp_target();
        int mx, dm;
        case (level_sel)
            2'b00: begin mx = day_max; dm = day_dim; end
            2'b01: begin mx = office_max; dm = office_dim; end
            default: begin mx = dark_max; dm = dark_dim; end
        endcase
        if (m_en == 0) return 0;
        return (m_dim != 0) ? dm : mx;
    endfunction

    task automatic model();
        int en0 = m_en, dim0 = m_dim;
        bit dexp = tick_1hz && (m_dl == 1);
        bit oexp = tick_1hz && (m_ol == 1);
        bit seton = (en_wr && en_wdata) || (key_press && key_wake_en);
        bit rsd = 0;
        if (rst) begin
            m_en = 0; m_dim = 0; m_dl = 0; m_ol = 0;
            return;
        end
        if (seton) begin
            m_en = 1; m_dim = 0;
        end else if (en_wr && !en_wdata) begin
            m_en = 0; m_dim = 0;
        end else if (en0 != 0) begin
            if (dim_wr) begin
                m_dim = dim_wdata;
                rsd = !dim_wdata;
            end else if (dexp) m_dim = 1;
            if (oexp) begin m_en = 0; m_dim = 0; end
        end
        if (seton) begin
            m_dl = secs(dim_tcode); m_ol = secs(off_tcode);
        end else if (en0 == 0) begin
            m_dl = 0; m_ol = 0;
        end else begin
            if (rsd) m_dl = secs(dim_tcode);
            else if (tick_1hz && m_dl > 0) m_dl--;
            if (tick_1hz && m_ol > 0) m_ol--;
        end
        dim0 = dim0;
    endtask

    task automatic check(string what, int act, int exp);
        vectors++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s %s: actual %0d expected %0d at %0t", cur_req, what, act, exp, $time);
        end
    endtask

    task automatic compare();
        check("target_code", target_code, exp_target());
        check("en_state", en_state, m_en);
        check("dim_state", dim_state, m_dim);
        check("bl_on", bl_on, m_en);
    endtask

    task automatic cyc1();
        tick_1hz = tick_run && tick_ph;
        tick_ph = !tick_ph;
        @(posedge clk);
        model();
        @(negedge clk);
        compare();
        en_wr = 0; dim_wr = 0; key_press = 0;
    endtask

    task automatic run(int n);
        for (int i = 0; i < n; i++) cyc1();
    endtask

    task automatic wr_en(bit v);
        en_wr = 1; en_wdata = v; cyc1();
    endtask

    task automatic wr_dim(bit v);
        dim_wr = 1; dim_wdata = v; cyc1();
    endtask

    task automatic finish_run();
        $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
        $finish;
    endtask

    always @(posedge clk) begin
        wd++;
        if (wd > 150000) begin
            errors++;
            $display("FAIL watchdog: actual %0d cycles expected below 150000", wd);
            finish_run();
        end
    end

    initial begin
        @(negedge clk);
        run(3);
        rst = 0;
        cur_req = "R2";   // reset state
        run(2);

        // R1 / R2 / R10: level selection without timers, full and dim codes
        cur_req = "R1";
        wr_en(1);
        for (int l = 0; l < 4; l++) begin level_sel = 2'(l); run(2); end
        cur_req = "R8";
        wr_dim(1);
        cur_req = "R10";  // office dim 90 exceeds office max 60
        for (int l = 0; l < 4; l++) begin level_sel = 2'(l); run(2); end
        cur_req = "R8";
        wr_dim(0);
        run(2);
        cur_req = "R4";
        wr_en(0);
        wr_dim(1);        // ignored while off
        run(2);

        // R5 / R6 / R7: short codes, max -> dim -> off
        tick_run = 1;
        cur_req = "R5";
        dim_tcode = 1; off_tcode = 2;
        wr_en(1);
        run(90);

        // R7: longest codes
        cur_req = "R7";
        dim_tcode = 14; off_tcode = 15;
        wr_en(1);
        run(260);

        // R3: restart via rewrite of enable
        cur_req = "R3";
        dim_tcode = 2; off_tcode = 3;
        wr_en(1);
        run(24);
        wr_en(1);
        run(80);

        // R8: dim clear restarts dim countdown only
        cur_req = "R8";
        dim_tcode = 1; off_tcode = 5;
        wr_en(1);
        run(25);
        wr_dim(0);
        run(30);
        wr_dim(0);
        run(80);

        // R9: key wake
        cur_req = "R9";
        key_wake_en = 0; key_press = 1; cyc1(); run(3);
        key_wake_en = 1; key_press = 1; cyc1(); run(5);

        // R4: clear mid-count stops countdowns
        cur_req = "R4";
        wr_en(0);
        run(120);

        // R12: code change mid-count
        cur_req = "R12";
        dim_tcode = 1; off_tcode = 2;
        wr_en(1);
        run(4);
        dim_tcode = 15; off_tcode = 0;
        run(60);

        // R11 and mixed: pseudo-random collisions
        cur_req = "R11";
        void'($urandom(7));
        for (int i = 0; i < 6000; i++) begin
            if ($urandom_range(0, 19) == 0) begin en_wr = 1; en_wdata = 1'($urandom_range(0, 1)); end
            if ($urandom_range(0, 9) == 0) begin dim_wr = 1; dim_wdata = 1'($urandom_range(0, 1)); end
            if ($urandom_range(0, 29) == 0) key_press = 1;
            if ($urandom_range(0, 99) == 0) key_wake_en = 1'($urandom_range(0, 1));
            if ($urandom_range(0, 199) == 0) begin
                dim_tcode = 4'($urandom_range(0, 2));
                off_tcode = 4'($urandom_range(0, 3));
            end
            if ($urandom_range(0, 49) == 0) level_sel = 2'($urandom_range(0, 3));
            cyc1();
        end

        finish_run();
    end
endmodule